// File: doc/BRIEF.md
# Pin-Controlled Power-Down Hold Unit

This block sits between the pins of a chip and its logic. It provides a low-power hold mode. Two request pins act as one power-down request, joined by OR. They take effect only while a configuration bit enables the feature. While the hold is active, the unit stops tracking its inputs. The logic sees the input values captured at the moment of entry. The pads keep the output values and output enables captured at that same moment, so a pad that was high-impedance stays high-impedance.

When both request pins have returned low, the unit does not let go at once. It waits a recovery interval, set as a cycle count, before the live paths reconnect. A new request during that interval sends the unit straight back into the hold. With the feature enabled, the two request pins are reserved for power-down, and the copies of them passed to the logic read as constant zero.

The request pins are asynchronous. They pass through a two-flop synchronizer before they are used. Every other pin is a level that is passed through or held. There is no data stream here, so no valid/ready handshake is needed and no back-pressure exists. Outside the hold, the data paths are purely combinational.

Top module: `pdhold_unit`

## Requirements
- R1: After reset the unit is in the run state: `fab_in` equals `pin_in`, and `pad_out`/`pad_oe` equal `core_out`/`core_oe`, in the same cycle.
- R2: While `pd_en` is 0, the request pins have no effect on any data output, which keeps following its live input.
- R3: With `pd_en` at 1, a high level on either `pd_req_a` or `pd_req_b` starts the hold. The values captured are the ones present at the third rising clock edge after the pin rises. From that edge on, the outputs stop following their inputs.
- R4: During the hold and the recovery interval, `fab_in` keeps the captured input value regardless of `pin_in`.
- R5: During the hold and the recovery interval, `pad_out` and `pad_oe` keep the captured values regardless of `core_out`/`core_oe`. Every bit whose enable was 0 at entry stays 0 (high-impedance).
- R6: While `pd_en` is 1, `fab_pd_a` and `fab_pd_b` read 0. While `pd_en` is 0, they follow `pd_req_a` and `pd_req_b` directly.
- R7: The outputs follow their live inputs again once RECOVER_CYCLES+2 rising edges have passed after both request pins read low. They then track from the third edge of the synchronized low onwards plus RECOVER_CYCLES edges, so the first live sample is RECOVER_CYCLES+3 edges after the drop.
- R8: A synchronized request that is seen during recovery returns the unit to the hold without reconnecting. The full recovery interval is counted again after the next release.
- R9: The hold stays in place for as long as at least one request pin is high, including when the request passes from one pin to the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_en | input | 1 | Configuration bit that enables power-down |
| pd_req_a | input | 1 | First power-down request pin (asynchronous) |
| pd_req_b | input | 1 | Second power-down request pin (asynchronous) |
| pin_in | input | N_IN | Input pin levels |
| core_out | input | N_OUT | Output values from the logic |
| core_oe | input | N_OUT | Output enables from the logic |
| fab_in | output | N_IN | Input values as presented to the logic |
| fab_pd_a | output | 1 | Request pin A as seen by the logic |
| fab_pd_b | output | 1 | Request pin B as seen by the logic |
| pad_out | output | N_OUT | Output values driven to the pads |
| pad_oe | output | N_OUT | Output enables driven to the pads |

## Verification
A request raised ahead of edge E1 freezes the outputs at E3, holding the values present just before E3. The bench therefore expects live values in the ticks for E1 and E2, including the value set in the E3 tick, and expects the frozen values from the following tick on. After the pins drop, the outputs stay frozen for RECOVER_CYCLES+2 ticks and are live in the next one. This is checked with a short recovery count so that both a release that comes one tick too early and one that comes one tick too late are caught. The pin-mask outputs and the passthrough paths are combinational, so each is checked in the same tick as its stimulus. Every expectation is queued when its stimulus is driven on the falling edge and compared 1 ns after the following rising edge.

// File: rtl/pdh_pkg.sv
package pdh_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_HOLD    = 2'd1,
    ST_RECOVER = 2'd2
  } pdh_state_e;
endpackage

// File: rtl/pdh_sync.sv
module pdh_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pdh_ctrl.sv
module pdh_ctrl
  import pdh_pkg::*;
#(
  parameter int RECOVER_CYCLES = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_eff,
  output pdh_state_e state_q,
  output logic       run_o
);
  localparam int CW = (RECOVER_CYCLES < 2) ? 1 : $clog2(RECOVER_CYCLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(RECOVER_CYCLES - 1);

  logic [CW-1:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      wait_q  <= '0;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (req_eff) state_q <= ST_HOLD;
        end
        ST_HOLD: begin
          if (!req_eff) begin
            state_q <= ST_RECOVER;
            wait_q  <= RELOAD;
          end
        end
        ST_RECOVER: begin
          if (req_eff) begin
            state_q <= ST_HOLD;
          end else if (wait_q == '0) begin
            state_q <= ST_RUN;
          end else begin
            wait_q <= wait_q - 1'b1;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign run_o = (state_q == ST_RUN);
endmodule

// File: rtl/pdh_freeze.sv
module pdh_freeze #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         track,
  input  logic [W-1:0] live,
  output logic [W-1:0] seen
);
  logic [W-1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     snap_q <= '0;
    else if (track) snap_q <= live;
  end

  assign seen = track ? live : snap_q;
endmodule

// File: rtl/pdhold_unit.sv
module pdhold_unit
  import pdh_pkg::*;
#(
  parameter int N_IN           = 8,
  parameter int N_OUT          = 8,
  parameter int SYNC_STAGES    = 2,
  parameter int RECOVER_CYCLES = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_en,
  input  logic             pd_req_a,
  input  logic             pd_req_b,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  output logic [N_IN-1:0]  fab_in,
  output logic             fab_pd_a,
  output logic             fab_pd_b,
  output logic [N_OUT-1:0] pad_out,
  output logic [N_OUT-1:0] pad_oe
);
  localparam int PADW = 2 * N_OUT;

  logic       req_raw;
  logic       req_s;
  logic       req_eff;
  logic       run;
  pdh_state_e state_q;
  logic [PADW-1:0] pad_live;
  logic [PADW-1:0] pad_seen;

  assign req_raw = pd_req_a | pd_req_b;

  pdh_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (req_raw),
    .q    (req_s)
  );

  assign req_eff = pd_en & req_s;

  pdh_ctrl #(.RECOVER_CYCLES(RECOVER_CYCLES)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_eff(req_eff),
    .state_q(state_q),
    .run_o  (run)
  );

  pdh_freeze #(.W(N_IN)) u_in_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .track(run),
    .live (pin_in),
    .seen (fab_in)
  );

  assign pad_live = {core_oe, core_out};

  pdh_freeze #(.W(PADW)) u_pad_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .track(run),
    .live (pad_live),
    .seen (pad_seen)
  );

  assign pad_out  = pad_seen[N_OUT-1:0];
  assign pad_oe   = pad_seen[PADW-1:N_OUT];
  assign fab_pd_a = pd_en ? 1'b0 : pd_req_a;
  assign fab_pd_b = pd_en ? 1'b0 : pd_req_b;
endmodule

// File: rtl/pdhold_unit_chk.sv
module pdhold_unit_chk
  import pdh_pkg::*;
#(
  parameter int N_IN           = 8,
  parameter int N_OUT          = 8,
  parameter int RECOVER_CYCLES = 500
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pd_en,
  input logic             req_s,
  input pdh_state_e       state_q,
  input logic [N_IN-1:0]  fab_in,
  input logic             fab_pd_a,
  input logic             fab_pd_b,
  input logic [N_OUT-1:0] pad_out,
  input logic [N_OUT-1:0] pad_oe
);
  int unsigned rec_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     rec_len <= 0;
    else if (state_q == ST_RECOVER) rec_len <= rec_len + 1;
    else                            rec_len <= 0;
  end

  AST_ENTRY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && $past(state_q) == ST_RUN) |-> $past(pd_en)); // R2

  AST_ENTRY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && pd_en && req_s) |=> (state_q == ST_HOLD)); // R3

  AST_IN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RUN && $past(state_q) != ST_RUN) |-> $stable(fab_in)); // R4

  AST_PAD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RUN && $past(state_q) != ST_RUN) |-> ($stable(pad_out) && $stable(pad_oe))); // R5

  AST_PIN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    pd_en |-> (!fab_pd_a && !fab_pd_b)); // R6

  AST_FULL_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && $past(state_q) == ST_RECOVER) |-> (rec_len == RECOVER_CYCLES)); // R7

  AST_REHOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RECOVER && pd_en && req_s) |=> (state_q == ST_HOLD)); // R8

  AST_HOLD_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && pd_en && req_s) |=> (state_q == ST_HOLD)); // R9
endmodule

bind pdhold_unit pdhold_unit_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .RECOVER_CYCLES(RECOVER_CYCLES)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pd_en   (pd_en),
  .req_s   (req_s),
  .state_q (state_q),
  .fab_in  (fab_in),
  .fab_pd_a(fab_pd_a),
  .fab_pd_b(fab_pd_b),
  .pad_out (pad_out),
  .pad_oe  (pad_oe)
);

// File: tb/pdhold_unit_test.sv
module pdhold_unit_test;
  localparam int REC = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pd_en = 1'b0;
  logic       pd_req_a = 1'b0;
  logic       pd_req_b = 1'b0;
  logic [7:0] pin_in = '0;
  logic [7:0] core_out = '0;
  logic [7:0] core_oe = '0;
  logic [7:0] fab_in;
  logic       fab_pd_a;
  logic       fab_pd_b;
  logic [7:0] pad_out;
  logic [7:0] pad_oe;

  pdhold_unit #(.N_IN(8), .N_OUT(8), .SYNC_STAGES(2), .RECOVER_CYCLES(REC)) uut (
    .clk(clk), .rst_n(rst_n), .pd_en(pd_en), .pd_req_a(pd_req_a), .pd_req_b(pd_req_b),
    .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
    .fab_in(fab_in), .fab_pd_a(fab_pd_a), .fab_pd_b(fab_pd_b),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [7:0] v_in;
    logic [7:0] v_out;
    logic [7:0] v_oe;
    logic       v_pa;
    logic       v_pb;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  logic [7:0] d_in, d_out, d_oe, h_in, h_out, h_oe;
  logic       d_pa, d_pb, d_en;

  task automatic pat(input int j);
    d_in  = 8'(j * 29 + 3);
    d_out = 8'(j * 53 + 11);
    d_oe  = 8'(j * 71 + 90);
  endtask

  // driver: applies stimulus on the falling edge and queues the result due after the next rising edge
  task automatic tick(input string tag, input bit live, input bit cap);
    exp_t e;
    @(negedge clk);
    pin_in = d_in; core_out = d_out; core_oe = d_oe;
    pd_req_a = d_pa; pd_req_b = d_pb; pd_en = d_en;
    if (cap) begin h_in = d_in; h_out = d_out; h_oe = d_oe; end
    e.v_in  = live ? d_in  : h_in;
    e.v_out = live ? d_out : h_out;
    e.v_oe  = live ? d_oe  : h_oe;
    e.v_pa  = d_en ? 1'b0 : d_pa;
    e.v_pb  = d_en ? 1'b0 : d_pb;
    e.tag   = tag;
    exp_q.push_back(e);
    @(posedge clk);
  endtask

  // monitor: compares one queued item 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (fab_in !== e.v_in || pad_out !== e.v_out || pad_oe !== e.v_oe ||
            fab_pd_a !== e.v_pa || fab_pd_b !== e.v_pb) begin
          fails++;
          $display("FAIL %s: act in=%h out=%h oe=%h pa=%b pb=%b exp in=%h out=%h oe=%h pa=%b pb=%b",
                   e.tag, fab_in, pad_out, pad_oe, fab_pd_a, fab_pd_b,
                   e.v_in, e.v_out, e.v_oe, e.v_pa, e.v_pb);
        end
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: act run not finished exp finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    d_en = 0; d_pa = 0; d_pb = 0;
    h_in = '0; h_out = '0; h_oe = '0;
    pat(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state passes everything through
    pat(1);
    tick("R1 reset passthrough", 1, 0);

    // R2 and R6: requests ignored while the feature is off, pins mirrored
    d_pa = 1;
    for (int j = 2; j < 7; j++) begin
      pat(j);
      tick("R2 R6 disabled request ignored", 1, 0);
    end
    d_pa = 0; d_pb = 1;
    pat(7);
    tick("R6 pin b mirrored", 1, 0);
    d_pb = 0;
    for (int j = 8; j < 11; j++) begin
      pat(j);
      tick("R2 idle", 1, 0);
    end
    d_en = 1;
    pat(11);
    tick("R6 pins masked", 1, 0);

    // R3: entry from pin a, frozen values from third edge
    d_pa = 1;
    pat(12); tick("R3 first edge live", 1, 0);
    pat(13); tick("R3 second edge live", 1, 0);
    pat(14); tick("R3 entry capture", 1, 1);
    for (int j = 15; j < 19; j++) begin
      pat(j);
      tick("R4 R5 held", 0, 0);
    end

    // R9: request moves from pin a to pin b
    d_pa = 0; d_pb = 1;
    for (int j = 20; j < 24; j++) begin
      pat(j);
      tick("R9 hold across pin swap", 0, 0);
    end

    // R7: release after the recovery interval
    d_pb = 0;
    for (int k = 0; k < REC + 2; k++) begin
      pat(30 + k);
      tick("R7 still held in recovery", 0, 0);
    end
    pat(45); tick("R7 released", 1, 0);
    pat(46); tick("R7 live after release", 1, 0);

    // R8: new request during recovery restarts the hold
    d_pb = 1;
    pat(50); tick("R3 pin b first edge", 1, 0);
    pat(51); tick("R3 pin b second edge", 1, 0);
    pat(52); tick("R3 pin b capture", 1, 1);
    pat(53); tick("R5 held", 0, 0);
    d_pb = 0;
    for (int k = 0; k < 3; k++) begin
      pat(60 + k);
      tick("R8 early recovery", 0, 0);
    end
    d_pa = 1;
    for (int k = 0; k < 4; k++) begin
      pat(70 + k);
      tick("R8 re-held", 0, 0);
    end
    d_pa = 0;
    for (int k = 0; k < REC + 2; k++) begin
      pat(80 + k);
      tick("R8 full recovery again", 0, 0);
    end
    pat(95); tick("R8 released", 1, 0);

    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule